// File: doc/BRIEF.md
# Shared-Channel Time-to-Digital Hit Bank

This block sits at the bottom of a pixel column and timestamps hits with a fine resolution of one delay tap. One delay line runs along the column, and its 32 tap outputs reach the block as a phase vector. The 45 pixels share nine conversion channels. Each channel serves five pixels that are spread out so that no two of them are neighbours. When any pixel of a group fires, the channel captures the phase vector for that cycle. It reduces the vector to a 5-bit fine-time code and tags the result with the position of the firing pixel inside its group. The channel then keeps that result untouched until the readout has collected it.

Readout runs on the fast serial clock, which is the block's only clock. A divide-by-eight phase counter marks the reference-clock edges. On a marked edge with no frame in progress, the block copies all nine channel results into a serial register in one step and frees the channels. It then shifts the frame out one bit per fast cycle. A frame is 81 bits long, and a new frame follows every 88 fast cycles.

Top module: `tdc_hit_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears every channel, the collision flags, the phase counter and the serial register. After reset, `ser_active_o`, `ser_data_o` and `coll_o` read 0, and the first frame carries nine invalid words.
- R2: The captured code is taken from the tap vector presented in the same cycle as the hit. It equals the lowest index i (0 to 30) with filtered tap i = 1 and filtered tap i+1 = 0. If no such index exists, the code is 31 when filtered tap 31 is 1 and 0 otherwise.
- R3: Before encoding, each inner tap i (1 to 30) is replaced by the majority of taps i-1, i and i+1. Taps 0 and 31 pass unchanged. A lone flipped tap therefore does not move the code.
- R4: Hit input bit p (0 to 44) belongs to channel p mod 9 with address p / 9. When several pixels of one group fire together, the lowest address is stored and `coll_o[channel]` goes high from the next cycle until that result is transferred.
- R5: A channel that holds a valid result ignores every further hit on its group until the transfer edge.
- R6: On a transfer edge, all channels hand over their contents at once and then read as invalid, with address and code zero and collision low. A hit presented on that same edge is captured as a fresh result.
- R7: A frame is 81 bits and channel 0 comes first. Each channel word is 9 bits, sent MSB first: valid, then address[2:0], then code[4:0]. `ser_frame_o` is high during the first bit only.
- R8: A phase counter runs from 0 to 7 and is 0 after reset. A frame loads only on an edge where the counter is 0 and no bits remain; the first load is the first edge after reset is released. `ser_active_o` stays high for exactly 81 cycles, and frames start every 88 cycles.
- R9: `ser_data_o` is 0 whenever `ser_active_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, eight times the reference rate |
| rst_n | input | 1 | Synchronous reset, active low |
| taps_i | input | 32 | Delay-line phase vector, bit 0 is the first tap |
| hit_i | input | 45 | Pixel hit strobes, bit p is pixel p |
| ser_data_o | output | 1 | Serial result stream |
| ser_frame_o | output | 1 | High on the first bit of a frame |
| ser_active_o | output | 1 | High while frame bits are being shifted out |
| coll_o | output | 9 | Per-channel flag: the held result came from a multi-pixel hit |

## Verification
A hit driven before edge N shows up in `coll_o` at edge N. Its word appears in the stream only after the next load edge: the valid bit of channel 0 is visible in the cycle after that edge, and channel c's word starts 9·c cycles later. The bench's reference model advances once per edge, using the same inputs the design samples there. Every output is compared half a period after each edge, so these latencies hold by construction of the compare. Directed scenarios then decode whole received frames. Some hits are placed on the exact load edge to pin down which frame they land in.

// File: rtl/tdc_bank_pkg.sv
// Package: shared default sizes for the shared-channel hit bank.
// Assumes a single fast clock with the reference edge derived inside.
package tdc_bank_pkg;
    localparam int TAPS_DEF    = 32;  // delay-line taps
    localparam int N_CH_DEF    = 9;   // conversion channels
    localparam int GRP_DEF     = 5;   // pixels per channel
    localparam int ADDR_W_DEF  = 3;   // in-group address width
    localparam int REF_DIV_DEF = 8;   // fast cycles per reference period
endpackage

// File: rtl/tdc_thermo_enc.sv
// Module: tdc_thermo_enc
// Smooths a thermometer-style tap vector with a 3-tap majority vote and
// returns the index of the first 1-to-0 step. Purely combinational.
// Assumes ones fill the low taps; end taps are not filtered.
module tdc_thermo_enc #(
    parameter int TAPS   = 32,
    parameter int CODE_W = $clog2(TAPS)
) (
    input  logic [TAPS-1:0]   taps_i,
    output logic [CODE_W-1:0] code_o
);
    logic [TAPS-1:0] filt;

    // Majority smoothing of each inner tap with its neighbours.
    for (genvar i = 0; i < TAPS; i++) begin : g_filt
        if (i == 0 || i == TAPS - 1) begin : g_end
            assign filt[i] = taps_i[i];
        end else begin : g_mid
            assign filt[i] = (taps_i[i-1] & taps_i[i]) |
                             (taps_i[i]   & taps_i[i+1]) |
                             (taps_i[i-1] & taps_i[i+1]);
        end
    end

    // Lowest falling step wins; with none, the top tap picks full or empty.
    always_comb begin
        code_o = filt[TAPS-1] ? CODE_W'(TAPS - 1) : '0;
        for (int i = TAPS - 2; i >= 0; i--) begin
            if (filt[i] && !filt[i+1]) code_o = CODE_W'(i);
        end
    end
endmodule

// File: rtl/tdc_channel.sv
// Module: tdc_channel
// One conversion channel shared by a pixel group. It captures the fine
// code and the lowest firing address, flags multi-pixel hits, and holds
// the result until the readout transfer frees it.
// Assumes code_i is already encoded from the taps of the current cycle.
module tdc_channel #(
    parameter int GRP    = 5,
    parameter int ADDR_W = 3,
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_i,
    input  logic [GRP-1:0]    grp_hit_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CODE_W-1:0] code_o,
    output logic              coll_o
);
    localparam int CNT_W = $clog2(GRP + 1);

    logic              valid_q, coll_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CODE_W-1:0] code_q;
    logic [ADDR_W-1:0] sel;
    logic [CNT_W-1:0]  nhits;
    logic              take;

    // Lowest firing address and number of simultaneous hits.
    always_comb begin
        sel   = '0;
        nhits = '0;
        for (int j = GRP - 1; j >= 0; j--) begin
            if (grp_hit_i[j]) sel = ADDR_W'(j);
        end
        for (int j = 0; j < GRP; j++) begin
            nhits = nhits + CNT_W'(grp_hit_i[j]);
        end
    end

    // Accept a hit only while empty or being emptied this edge.
    assign take = (|grp_hit_i) && (!valid_q || xfer_i);

    // Result register: capture, hold, or clear on transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            coll_q  <= 1'b0;
            addr_q  <= '0;
            code_q  <= '0;
        end else if (take) begin
            valid_q <= 1'b1;
            coll_q  <= (nhits > CNT_W'(1));
            addr_q  <= sel;
            code_q  <= code_i;
        end else if (xfer_i) begin
            valid_q <= 1'b0;
            coll_q  <= 1'b0;
            addr_q  <= '0;
            code_q  <= '0;
        end
    end

    assign valid_o = valid_q;
    assign addr_o  = addr_q;
    assign code_o  = code_q;
    assign coll_o  = coll_q;

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !xfer_i) |=> (valid_q && $stable(addr_q) && $stable(code_q)));

    // R6
    xfer_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_i && !(|grp_hit_i)) |=> (!valid_q && !coll_q));

    // R4
    coll_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coll_q |-> valid_q);

    // R4
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (int'(addr_q) < GRP));
endmodule

// File: rtl/tdc_frame_shifter.sv
// Module: tdc_frame_shifter
// Marks reference edges with a divide-by-REF_DIV phase counter, loads the
// whole channel frame on a marked edge when idle, and shifts it out MSB
// first, one bit per fast cycle.
// Assumes frame_i holds channel 0 in its most significant word.
module tdc_frame_shifter #(
    parameter int N_CH    = 9,
    parameter int WORD_W  = 9,
    parameter int REF_DIV = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_CH*WORD_W-1:0] frame_i,
    output logic                   xfer_o,
    output logic                   ser_data_o,
    output logic                   ser_frame_o,
    output logic                   ser_active_o
);
    localparam int FRAME_W = N_CH * WORD_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int PH_W    = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;

    logic [PH_W-1:0]    phase_q;
    logic [FRAME_W-1:0] sr_q;
    logic [CNT_W-1:0]   left_q;

    // Reference-edge phase: wraps every REF_DIV fast cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)                                phase_q <= '0;
        else if (phase_q == PH_W'(REF_DIV - 1))    phase_q <= '0;
        else                                       phase_q <= phase_q + 1'b1;
    end

    assign xfer_o = (phase_q == '0) && (left_q == '0);

    // Frame register: parallel load on transfer, otherwise shift while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            left_q <= '0;
        end else if (xfer_o) begin
            sr_q   <= frame_i;
            left_q <= CNT_W'(FRAME_W);
        end else if (left_q != '0) begin
            sr_q   <= {sr_q[FRAME_W-2:0], 1'b0};
            left_q <= left_q - 1'b1;
        end
    end

    assign ser_active_o = (left_q != '0);
    assign ser_frame_o  = (left_q == CNT_W'(FRAME_W));
    assign ser_data_o   = ser_active_o & sr_q[FRAME_W-1];

    // R8
    frame_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_frame_o |-> (phase_q == PH_W'(1 % REF_DIV)));

    // R8
    frame_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_frame_o |=> !ser_frame_o);

    // R8
    frame_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_active_o && !ser_frame_o) |-> $past(ser_active_o));
endmodule

// File: rtl/tdc_hit_bank.sv
// Module: tdc_hit_bank (top)
// Column hit bank: one shared tap encoder, N_CH channels each serving a
// strided group of GRP pixels, and a serial frame readout.
// Assumes hit bit p belongs to channel p mod N_CH, address p / N_CH.
module tdc_hit_bank
    import tdc_bank_pkg::*;
#(
    parameter int TAPS    = TAPS_DEF,
    parameter int N_CH    = N_CH_DEF,
    parameter int GRP     = GRP_DEF,
    parameter int ADDR_W  = ADDR_W_DEF,
    parameter int REF_DIV = REF_DIV_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TAPS-1:0]     taps_i,
    input  logic [N_CH*GRP-1:0] hit_i,
    output logic                ser_data_o,
    output logic                ser_frame_o,
    output logic                ser_active_o,
    output logic [N_CH-1:0]     coll_o
);
    localparam int CODE_W  = $clog2(TAPS);
    localparam int WORD_W  = 1 + ADDR_W + CODE_W;
    localparam int FRAME_W = N_CH * WORD_W;

    logic [CODE_W-1:0]  code;
    logic               xfer;
    logic [FRAME_W-1:0] frame;

    // Single encoder: every channel sees the same delay line.
    tdc_thermo_enc #(.TAPS(TAPS), .CODE_W(CODE_W)) u_enc (
        .taps_i (taps_i),
        .code_o (code)
    );

    // Channels with strided pixel groups; channel 0 lands at the frame MSB.
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [GRP-1:0]    grp;
        logic              v;
        logic [ADDR_W-1:0] a;
        logic [CODE_W-1:0] cd;

        for (genvar j = 0; j < GRP; j++) begin : g_pix
            assign grp[j] = hit_i[j*N_CH + c];
        end

        tdc_channel #(.GRP(GRP), .ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .xfer_i    (xfer),
            .grp_hit_i (grp),
            .code_i    (code),
            .valid_o   (v),
            .addr_o    (a),
            .code_o    (cd),
            .coll_o    (coll_o[c])
        );

        assign frame[(N_CH-1-c)*WORD_W +: WORD_W] = {v, a, cd};
    end

    tdc_frame_shifter #(.N_CH(N_CH), .WORD_W(WORD_W), .REF_DIV(REF_DIV)) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_i      (frame),
        .xfer_o       (xfer),
        .ser_data_o   (ser_data_o),
        .ser_frame_o  (ser_frame_o),
        .ser_active_o (ser_active_o)
    );
endmodule

// File: tb/sim_tdc_hit_bank.sv
// Bench for tdc_hit_bank: a behavioural per-edge model compared on every
// cycle, plus directed frame decodes.
module sim_tdc_hit_bank;
    localparam int NCH = 9, FB = 81;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] taps_r = '0;
    logic [44:0] hit_r = '0;
    logic        ser_data_o, ser_frame_o, ser_active_o;
    logic [8:0]  coll_o;

    int total = 0, bad = 0;
    bit finished = 0;

    tdc_hit_bank u0 (
        .clk (clk), .rst_n (rst_n), .taps_i (taps_r), .hit_i (hit_r),
        .ser_data_o (ser_data_o), .ser_frame_o (ser_frame_o),
        .ser_active_o (ser_active_o), .coll_o (coll_o)
    );

    always #10 clk = ~clk;

    // Reference model state.
    bit m_v[NCH];
    int m_a[NCH], m_c[NCH];
    bit m_coll[NCH];
    int m_ph = 0, m_left = 0;
    bit m_sr[FB];

    bit rx[FB];
    int rx_idx = FB, frames_done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int enc(input logic [31:0] t);
        logic [31:0] f;
        for (int i = 0; i < 32; i++) begin
            if (i == 0 || i == 31) f[i] = t[i];
            else f[i] = (int'(t[i-1]) + int'(t[i]) + int'(t[i+1])) >= 2;
        end
        for (int i = 0; i < 31; i++) if (f[i] && !f[i+1]) return i;
        return f[31] ? 31 : 0;
    endfunction

    task automatic model_step();
        bit load;
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_v[c] = 0; m_a[c] = 0; m_c[c] = 0; m_coll[c] = 0;
            end
            for (int k = 0; k < FB; k++) m_sr[k] = 0;
            m_ph = 0; m_left = 0;
        end else begin
            load = (m_ph == 0) && (m_left == 0);
            if (load) begin
                for (int c = 0; c < NCH; c++) begin
                    m_sr[c*9] = m_v[c];
                    for (int b = 0; b < 3; b++) m_sr[c*9+1+b] = m_a[c][2-b];
                    for (int b = 0; b < 5; b++) m_sr[c*9+4+b] = m_c[c][4-b];
                end
                m_left = FB;
            end else if (m_left > 0) begin
                for (int k = 0; k < FB-1; k++) m_sr[k] = m_sr[k+1];
                m_sr[FB-1] = 0;
                m_left--;
            end
            for (int c = 0; c < NCH; c++) begin
                int first = -1, n = 0;
                for (int j = 0; j < 5; j++) if (hit_r[j*9+c]) begin
                    n++;
                    if (first < 0) first = j;
                end
                if ((!m_v[c] || load) && n > 0) begin
                    m_v[c] = 1; m_a[c] = first; m_c[c] = enc(taps_r); m_coll[c] = (n > 1);
                end else if (load) begin
                    m_v[c] = 0; m_a[c] = 0; m_c[c] = 0; m_coll[c] = 0;
                end
            end
            m_ph = (m_ph + 1) % 8;
        end
    endtask

    task automatic compare();
        bit ea, ef, ed;
        logic [8:0] ec;
        ea = (m_left > 0);
        ef = (m_left == FB);
        ed = ea ? m_sr[0] : 1'b0;
        for (int c = 0; c < NCH; c++) ec[c] = m_coll[c];
        chk(ser_active_o == ea, "R8 active", int'(ser_active_o), int'(ea));
        chk(ser_frame_o == ef, "R7 frame flag", int'(ser_frame_o), int'(ef));
        if (ea) chk(ser_data_o == ed, "R7 data bit", int'(ser_data_o), int'(ed));
        else    chk(ser_data_o == 1'b0, "R9 idle data", int'(ser_data_o), 0);
        chk(coll_o == ec, "R4 collision flags", int'(coll_o), int'(ec));
    endtask

    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
        if (ser_active_o) begin
            if (ser_frame_o) rx_idx = 0;
            if (rx_idx < FB) begin
                rx[rx_idx] = ser_data_o;
                rx_idx++;
                if (rx_idx == FB) frames_done++;
            end
        end
    endtask

    task automatic wait_frame_done();
        int n = frames_done;
        for (int i = 0; i < 400 && frames_done == n; i++) cycle();
    endtask

    task automatic wait_frame_start();
        for (int i = 0; i < 200; i++) begin
            cycle();
            if (ser_frame_o) break;
        end
    endtask

    task automatic wait_load_next();
        for (int i = 0; i < 200 && !(m_ph == 0 && m_left == 0); i++) cycle();
    endtask

    task automatic check_word(input int c, input int v, input int a, input int cd, input string req);
        int rv, ra, rc;
        rv = int'(rx[c*9]);
        ra = 0; rc = 0;
        for (int b = 0; b < 3; b++) ra = ra*2 + int'(rx[c*9+1+b]);
        for (int b = 0; b < 5; b++) rc = rc*2 + int'(rx[c*9+4+b]);
        chk(rv == v && ra == a && rc == cd, req, rv*256 + ra*32 + rc, v*256 + a*32 + cd);
    endtask

    task automatic hit1(input int p, input logic [31:0] t);
        hit_r = '0; hit_r[p] = 1'b1; taps_r = t;
        cycle();
        hit_r = '0;
    endtask

    initial begin
        // R1 reset
        repeat (4) cycle();
        chk(!ser_active_o && !ser_data_o && coll_o == '0, "R1 reset outputs", int'(coll_o), 0);
        rst_n = 1'b1;
        wait_frame_done();
        for (int c = 0; c < NCH; c++) check_word(c, 0, 0, 0, "R1 first frame empty");

        // Directed captures right after a frame start.
        wait_frame_start();
        hit1(9, 32'h0000_00FF);                       // ch0 addr1 code7
        hit_r = '0; hit_r[2] = 1; hit_r[20] = 1; taps_r = 32'h0000_FFFF;
        cycle(); hit_r = '0;                          // ch2 collision
        chk(coll_o[2] == 1'b1, "R4 collision raised", int'(coll_o[2]), 1);
        hit1(1, 32'h0000_0007);                       // ch1 addr0 code2
        hit_r = '0; hit_r[10] = 1; hit_r[40] = 1; taps_r = 32'hFFFF_FFFF;
        cycle(); hit_r = '0;                          // ch1 ignored (R5), ch4 full
        hit1(5, 32'h0000_00F7);                       // ch5 bubble, code7
        hit1(24, 32'h0000_0000);                      // ch6 empty
        hit1(35, 32'h0000_0400);                      // ch8 lone one
        hit1(16, 32'hFFFF_0000);                      // ch7 ones high

        // R6: hits exactly on the load edge.
        wait_load_next();
        hit_r = '0; hit_r[3] = 1; hit_r[0] = 1; taps_r = 32'h0000_003F;
        cycle(); hit_r = '0;
        chk(coll_o[2] == 1'b0, "R6 collision cleared on transfer", int'(coll_o[2]), 0);

        wait_frame_done();
        check_word(0, 1, 1, 7,  "R2 ch0 word");
        check_word(1, 1, 0, 2,  "R5 ch1 held first hit");
        check_word(2, 1, 0, 15, "R4 ch2 lowest address");
        check_word(3, 0, 0, 0,  "R6 ch3 edge hit not in this frame");
        check_word(4, 1, 4, 31, "R2 ch4 all ones");
        check_word(5, 1, 0, 7,  "R3 ch5 bubble suppressed");
        check_word(6, 1, 2, 0,  "R2 ch6 all zeros");
        check_word(7, 1, 1, 31, "R2 ch7 no falling step");
        check_word(8, 1, 3, 0,  "R3 ch8 lone tap suppressed");

        wait_frame_done();
        check_word(0, 1, 0, 5, "R6 ch0 fresh capture on edge");
        check_word(3, 1, 0, 5, "R6 ch3 fresh capture on edge");
        check_word(1, 0, 0, 0, "R6 ch1 freed after transfer");

        // Random traffic, compared every cycle.
        for (int i = 0; i < 2500; i++) begin
            int k = $urandom_range(0, 32);
            taps_r = (k == 32) ? 32'hFFFF_FFFF : ((32'h1 << k) - 32'h1);
            if ($urandom_range(0, 3) == 0) taps_r[$urandom_range(0, 31)] ^= 1'b1;
            hit_r = '0;
            if ($urandom_range(0, 2) == 0) hit_r[$urandom_range(0, 44)] = 1'b1;
            if ($urandom_range(0, 5) == 0) hit_r[$urandom_range(0, 44)] = 1'b1;
            cycle();
        end
        hit_r = '0;
        repeat (90) cycle();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule